// File: doc/BRIEF.md
# Paint Memory with Undo History

This block keeps the on/off picture of an 8x8 light canvas together with a short history of the strokes that lit it. Each stroke arrives as a one-cycle draw pulse carrying a 3-bit row code and a 3-bit column code. The addressed cell is turned on, and if it really changed state the stroke is recorded. A one-cycle undo pulse turns off the cell named by the most recent recorded stroke and removes that record.

The canvas is held as one word per column. Each word has one bit per row and is stored active-low, so a zero bit is a lit cell. A combinational read port gives the word of any column to a display scanner. The number of strokes held in the history is brought out so the undo depth can be observed. The history keeps only the newest four strokes. A stroke that arrives when it is full pushes out the oldest one, and that cell can no longer be undone.

Top module: `paint_mem_undo`

## Requirements
- R1: While `rst_n` is low and after it is released, every column word reads 8'hFF (all cells off) and `hist_count` is 0.
- R2: Row code r selects bit position 7-r of the column word: code 0 clears bit 7 (mask 8'h7F) and code 7 clears bit 0 (mask 8'hFE).
- R3: A draw pulse ANDs the decoded mask into the word of column `col_code`. The other bits and the other columns keep their values.
- R4: A stroke is recorded (`hist_count` rises by one, capped as in R5) only when the draw changes the column word. Drawing a cell that is already lit changes neither the canvas nor `hist_count`.
- R5: `hist_count` never exceeds 4. A stroke recorded when four are held drops the oldest one, and the three newer ones plus the new one stay undoable.
- R6: An undo pulse with `hist_count` above 0 replaces the newest stroke's column word with the XNOR of that word and the stroke's mask, which turns the cell off, and lowers `hist_count` by one.
- R7: An undo pulse with `hist_count` equal to 0 changes neither the canvas nor `hist_count`.
- R8: When undo and draw pulse in the same cycle, only the undo takes effect and the draw is dropped.
- R9: `rd_word` is the word of column `rd_col` without a clock delay. A write shows up on it from the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| draw_pulse | input | 1 | One-cycle request to light a cell |
| row_code | input | 3 | Row of the cell to light |
| col_code | input | 3 | Column of the cell to light |
| undo_pulse | input | 1 | One-cycle request to remove the newest stroke |
| rd_col | input | 3 | Column selected on the read port |
| rd_word | output | 8 | Active-low row bits of column `rd_col` |
| hist_count | output | 3 | Number of strokes held in the history (0 to 4) |

## Verification
The hardest case to reach is the drop of the oldest stroke. It only shows up after more than four distinct cells have been lit, all held strokes have been undone, and the canvas still holds the cell that was pushed out. The bench lights five cells in different columns and rows, undoes four times, then undoes once more. The first cell must still be lit after the last two undos, and `hist_count` must stay at zero. The same-cycle undo and draw case is also staged so that the draw would light a new cell if it were not dropped.

// File: rtl/paint_pkg.sv
package paint_pkg;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int RW   = $clog2(ROWS);
  localparam int CW   = $clog2(COLS);

  typedef struct packed {
    logic [CW-1:0]   col;
    logic [ROWS-1:0] mask;
  } stroke_t;
endpackage

// File: rtl/paint_row_mask.sv
module paint_row_mask
  import paint_pkg::*;
(
  input  logic [RW-1:0]   code,
  output logic [ROWS-1:0] mask
);
  for (genvar b = 0; b < ROWS; b++) begin : g_bit
    assign mask[b] = (code != RW'(ROWS - 1 - b));
  end
endmodule

// File: rtl/paint_canvas.sv
module paint_canvas
  import paint_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CW-1:0]        wr_col,
  input  logic [ROWS-1:0]      wr_word,
  output logic [COLS*ROWS-1:0] words
);
  for (genvar g = 0; g < COLS; g++) begin : g_col
    logic [ROWS-1:0] word_q;
    logic            hit;

    assign hit = wr_en && (wr_col == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (hit) begin
        word_q <= wr_word;
      end
    end

    assign words[g*ROWS +: ROWS] = word_q;
  end
endmodule

// File: rtl/paint_undo_stack.sv
module paint_undo_stack
  import paint_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  logic    pop,
  input  stroke_t push_data,
  output stroke_t newest,
  output logic [NW-1:0] count
);
  stroke_t       slot_q [DEPTH];
  stroke_t       slot_d [DEPTH];
  logic [NW-1:0] count_q, count_d;
  logic          full;

  assign full = (count_q == NW'(DEPTH));

  always_comb begin
    slot_d  = slot_q;
    count_d = count_q;
    if (pop && count_q != '0) begin
      count_d = count_q - 1'b1;
    end else if (push) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
        slot_d[DEPTH-1] = push_data;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (count_q == NW'(i)) slot_d[i] = push_data;
        end
        count_d = count_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      count_q <= count_d;
      slot_q  <= slot_d;
    end
  end

  always_comb begin
    newest = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (count_q == NW'(i + 1)) newest = slot_q[i];
    end
  end

  assign count = count_q;
endmodule

// File: rtl/paint_mem_undo.sv
module paint_mem_undo
  import paint_pkg::*;
#(
  parameter int HIST_DEPTH = 4,
  localparam int NW = $clog2(HIST_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            draw_pulse,
  input  logic [RW-1:0]   row_code,
  input  logic [CW-1:0]   col_code,
  input  logic            undo_pulse,
  input  logic [CW-1:0]   rd_col,
  output logic [ROWS-1:0] rd_word,
  output logic [NW-1:0]   hist_count
);
  logic [COLS*ROWS-1:0] canvas_flat;
  logic [ROWS-1:0]      row_mask, cur_word, lit_word, undo_word;
  logic                 undo_ok, draw_ok, wr_en;
  logic [CW-1:0]        wr_col;
  logic [ROWS-1:0]      wr_word;
  stroke_t              newest, push_data;

  paint_row_mask u_mask (
    .code (row_code),
    .mask (row_mask)
  );

  assign cur_word  = canvas_flat[col_code*ROWS +: ROWS];
  assign lit_word  = cur_word & row_mask;
  assign undo_word = ~(canvas_flat[newest.col*ROWS +: ROWS] ^ newest.mask);

  assign undo_ok = undo_pulse && (hist_count != '0);
  assign draw_ok = draw_pulse && !undo_pulse && (lit_word != cur_word);

  always_comb begin
    wr_en   = undo_ok || draw_ok;
    wr_col  = col_code;
    wr_word = lit_word;
    if (undo_ok) begin
      wr_col  = newest.col;
      wr_word = undo_word;
    end
  end

  assign push_data = '{col: col_code, mask: row_mask};

  paint_canvas u_canvas (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_col  (wr_col),
    .wr_word (wr_word),
    .words   (canvas_flat)
  );

  paint_undo_stack #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (draw_ok),
    .pop       (undo_pulse),
    .push_data (push_data),
    .newest    (newest),
    .count     (hist_count)
  );

  assign rd_word = canvas_flat[rd_col*ROWS +: ROWS];
endmodule

// File: rtl/paint_mem_chk.sv
module paint_mem_chk
  import paint_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 draw_pulse,
  input logic                 undo_pulse,
  input logic [NW-1:0]        hist_count,
  input logic [COLS*ROWS-1:0] canvas_flat
);
  p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hist_count <= NW'(DEPTH));

  p_empty_undo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_pulse && hist_count == '0) |=> ($stable(canvas_flat) && hist_count == '0));

  p_pop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_pulse && hist_count != '0) |=> (hist_count == $past(hist_count) - 1'b1));

  p_undo_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (undo_pulse && draw_pulse) |=> (hist_count <= $past(hist_count)));

  p_draw_only_lights_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_pulse && !undo_pulse) |=> ((canvas_flat & $past(canvas_flat)) == canvas_flat));

  p_no_push_if_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (draw_pulse && !undo_pulse) |=> (!$stable(canvas_flat) || $stable(hist_count)));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!draw_pulse && !undo_pulse) |=> ($stable(canvas_flat) && $stable(hist_count)));
endmodule

bind paint_mem_undo paint_mem_chk #(.DEPTH(HIST_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .draw_pulse  (draw_pulse),
  .undo_pulse  (undo_pulse),
  .hist_count  (hist_count),
  .canvas_flat (canvas_flat)
);

// File: tb/tb_paint_mem_undo.sv
`timescale 1ns/1ps
module tb_paint_mem_undo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       draw_pulse, undo_pulse;
  logic [2:0] row_code, col_code, rd_col;
  logic [7:0] rd_word;
  logic [2:0] hist_count;

  int checks = 0;
  int fails  = 0;

  logic [7:0] exp_w [8];
  logic [7:0] st_m  [4];
  logic [2:0] st_c  [4];
  int         st_n;

  paint_mem_undo dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .draw_pulse (draw_pulse),
    .row_code   (row_code),
    .col_code   (col_code),
    .undo_pulse (undo_pulse),
    .rd_col     (rd_col),
    .rd_word    (rd_word),
    .hist_count (hist_count)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int c = 0; c < 8; c++) begin
      rd_col = c[2:0];
      #0.1;
      chk(tag, rd_word, exp_w[c]);
    end
    chk({tag, " count"}, {5'd0, hist_count}, st_n[7:0]);
  endtask

  function automatic logic [7:0] mask_of(input int r);
    return ~(8'h80 >> r);
  endfunction

  task automatic model_draw(input int r, input int c);
    logic [7:0] m = mask_of(r);
    if ((exp_w[c] & m) != exp_w[c]) begin
      exp_w[c] = exp_w[c] & m;
      if (st_n == 4) begin
        for (int i = 0; i < 3; i++) begin
          st_m[i] = st_m[i+1];
          st_c[i] = st_c[i+1];
        end
        st_m[3] = m;
        st_c[3] = c[2:0];
      end else begin
        st_m[st_n] = m;
        st_c[st_n] = c[2:0];
        st_n++;
      end
    end
  endtask

  task automatic model_undo();
    if (st_n > 0) begin
      st_n--;
      exp_w[st_c[st_n]] = exp_w[st_c[st_n]] | ~st_m[st_n];
    end
  endtask

  task automatic draw(input int r, input int c);
    @(negedge clk);
    row_code = r[2:0]; col_code = c[2:0]; draw_pulse = 1'b1;
    @(negedge clk);
    draw_pulse = 1'b0;
    model_draw(r, c);
  endtask

  task automatic undo();
    @(negedge clk);
    undo_pulse = 1'b1;
    @(negedge clk);
    undo_pulse = 1'b0;
    model_undo();
  endtask

  task automatic t_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_decode();
    draw(0, 2);
    rd_col = 3'd2; #0.1;
    chk("R2 row0 mask", rd_word, 8'h7F);
    draw(7, 2);
    rd_col = 3'd2; #0.1;
    chk("R2 row7 mask", rd_word, 8'h7E);
    chk_all("R3 and into column");
  endtask

  task automatic t_relight();
    draw(0, 2);
    chk_all("R4 relight no push");
  endtask

  task automatic t_undo();
    undo();
    chk_all("R6 undo newest");
    undo();
    chk_all("R6 undo second");
  endtask

  task automatic t_empty();
    undo();
    chk_all("R7 empty undo");
  endtask

  task automatic t_overflow();
    draw(1, 0); draw(2, 1); draw(3, 2); draw(4, 3); draw(5, 4);
    chk_all("R5 full after five");
    for (int i = 0; i < 4; i++) undo();
    chk_all("R5 oldest dropped");
    rd_col = 3'd0; #0.1;
    chk("R5 oldest cell still lit", rd_word, 8'hBF);
    undo();
    chk_all("R5 R7 undo past dropped");
  endtask

  task automatic t_both();
    draw(6, 5);
    chk_all("R3 draw col5");
    @(negedge clk);
    row_code = 3'd3; col_code = 3'd6; draw_pulse = 1'b1; undo_pulse = 1'b1;
    @(negedge clk);
    draw_pulse = 1'b0; undo_pulse = 1'b0;
    model_undo();
    chk_all("R8 undo wins");
  endtask

  task automatic t_read();
    @(negedge clk);
    rd_col = 3'd4; row_code = 3'd0; col_code = 3'd4; draw_pulse = 1'b1;
    #0.5;
    chk("R9 before edge", rd_word, exp_w[4]);
    @(posedge clk);
    #0.5;
    chk("R9 after edge", rd_word, exp_w[4] & 8'h7F);
    @(negedge clk);
    draw_pulse = 1'b0;
    model_draw(0, 4);
    chk_all("R9 final state");
  endtask

  initial begin
    rst_n = 1'b0;
    draw_pulse = 1'b0; undo_pulse = 1'b0;
    row_code = '0; col_code = '0; rd_col = '0;
    st_n = 0;
    for (int c = 0; c < 8; c++) exp_w[c] = 8'hFF;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_relight();
    t_undo();
    t_empty();
    t_overflow();
    t_both();
    t_read();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule